// File: doc/BRIEF.md
# Multi-Match System Timer with Watchdog

This block is a free-running 32-bit system timer for a processor subsystem. A single up-counter advances by one on every clock cycle in which the tick input is high. Four compare channels each hold a 32-bit target value. When the counter takes on a channel's value, the channel records an event in a status register and raises its interrupt line, but only if that channel is enabled. Software acknowledges an event by writing a one to its status bit. Software can also load the counter at any time, and counting resumes upward from the loaded value.

Compare channel 3 has a second use as a one-shot watchdog. If software arms the watchdog and then fails to move the counter or the channel-3 target before they meet, the block pulses a system reset request and disarms itself. A small register bus with separate read and write strobes gives access to all registers. Read data and the error flag are registered and appear in the cycle after the read strobe.

Two state machines carry the control. The watchdog machine has the states WD_OFF (disarmed), WD_ARMED and WD_FIRE (the cycle in which the reset request is driven). Its transitions are *arm* (WD_OFF to WD_ARMED on a write with bit 0 set), *disarm* (WD_ARMED to WD_OFF on a write with bit 0 clear), *expire* (WD_ARMED to WD_FIRE on a channel-3 match), *settle* (WD_FIRE to WD_OFF) and *rearm* (WD_FIRE to WD_ARMED on a write with bit 0 set in that cycle). The bus response machine has the states RSP_IDLE, RSP_DATA and RSP_FAULT. A read of a mapped word moves it to RSP_DATA, a read of anything else moves it to RSP_FAULT, and a cycle with no read returns it to RSP_IDLE.

Top module: `ostimer_top`

## Requirements
- R1: After reset the counter, all four targets, the status bits, the interrupt enables and the watchdog word read as zero, every irq line is low and reset_req is low.
- R2: In a cycle with tick_en high and no counter write, the counter becomes its old value plus one, modulo 2^32 (0xFFFFFFFF advances to 0). A counter write (offset 0x10) loads the written value and takes priority over a tick in the same cycle. With neither, the counter holds.
- R3: A match event on channel n happens only in a cycle where the counter is updated (tick or load) and its new value equals target n (targets at offsets 0x00, 0x04, 0x08, 0x0C for n = 0..3). A counter that sits still on a target value gives no further events.
- R4: A match event on channel n sets status bit n (bit n of offset 0x14) only if interrupt-enable bit n (bit n of offset 0x1C) was set before that edge. irq[n] is high exactly while status bit n is set.
- R5: A write to offset 0x14 clears each status bit written as 1 and leaves the others. A match event in the same cycle keeps its bit set.
- R6: The interrupt-enable register at 0x1C stores only bits 11:0 of the written value; bits 31:12 read as zero.
- R7: A channel-3 match while bit 0 of the watchdog word (offset 0x18) is set drives reset_req high for exactly the one following cycle and clears the whole watchdog word to 0. This does not depend on interrupt-enable bit 3.
- R8: A channel-3 match while watchdog bit 0 is clear gives no reset request, and the watchdog word keeps its stored value.
- R9: A word is mapped when address bits 1:0 are zero and the address is below 0x20. A read of any other address returns 0 and raises bus_err for one cycle. A write to such an address changes no register. bus_err is low in every cycle that does not follow an unmapped read.
- R10: bus_rdata carries the value the addressed register held before the edge at which bus_rd was sampled. It is valid in the cycle after that edge and is not affected by a write in the same cycle.
- R11: The watchdog follows the arm, disarm, expire, settle and rearm transitions named above. In WD_FIRE, a write with bit 0 set rearms it straight away, and the watchdog word then reads back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter advance enable, one count per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Registered read data, valid the cycle after bus_rd |
| bus_err | output | 1 | High for one cycle after a read of an unmapped address |
| irq | output | 4 | Per-channel interrupt lines, one per compare channel |
| reset_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
If the counter's state is wrong, it shows up at the first read of offset 0x10 and also in the timing of the next match. The irq lines and the status readback then move one cycle earlier or later than the bench model, or not at all. A wrong watchdog state is visible in the cycle right after the channel-3 match edge: reset_req is either missing or doubled, and a readback of the watchdog word shows the bit 0 that should have been cleared. A mistake in the bus decode or the response machine shows up in the very next cycle as a wrong bus_err, or as data from the wrong slot. The random phase keeps loading the counter a few counts below the targets. This makes events, write-one-to-clear and watchdog expiry collide often, which brings out priority mistakes within a handful of cycles.

// File: rtl/ostimer_pkg.sv
package ostimer_pkg;

    localparam int NUM_CH     = 4;
    localparam int BYTE_BITS  = 2;
    localparam int SLOT_BITS  = 3;
    localparam int MAP_TOP    = BYTE_BITS + SLOT_BITS;

    localparam int SLOT_COUNT = 4;
    localparam int SLOT_STAT  = 5;
    localparam int SLOT_WDOG  = 6;
    localparam int SLOT_IEN   = 7;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DATA  = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;

    typedef struct packed {
        logic [NUM_CH-1:0] match;
        logic              count;
        logic              stat;
        logic              wdog;
        logic              ien;
    } wr_strobe_t;

endpackage

// File: rtl/ostimer_counter.sv
module ostimer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next,
    output logic             cnt_upd
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // a software load has priority over a tick in the same cycle
    always_comb begin
        cnt_upd  = load | tick_en;
        cnt_next = load ? load_val : (cnt_q + ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_upd) begin
            cnt_q <= cnt_next;
        end
    end

endmodule

// File: rtl/ostimer_match_chan.sv
module ostimer_match_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             target_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             cnt_upd,
    input  logic             enable,
    input  logic             clear,
    output logic [CNT_W-1:0] target_q,
    output logic             hit,
    output logic             set_evt,
    output logic             status_q
);

    // an event exists only when the counter is written or stepped this cycle
    always_comb begin
        hit     = cnt_upd && (cnt_next == target_q);
        set_evt = hit && enable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
        end else if (target_we) begin
            target_q <= wdata;
        end
    end

    // a fresh event outranks a write-one-to-clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (set_evt) begin
            status_q <= 1'b1;
        end else if (clear) begin
            status_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ostimer_watchdog.sv
module ostimer_watchdog
    import ostimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             expire_hit,
    output logic [CNT_W-1:0] wd_word,
    output logic             reset_req
);

    wd_state_e        state_q;
    wd_state_e        state_n;
    logic [CNT_W-1:1] upper_q;
    logic             expire;

    always_comb begin
        expire  = (state_q == WD_ARMED) && expire_hit;
        state_n = state_q;
        unique case (state_q)
            WD_OFF: begin
                if (wr && wdata[0]) state_n = WD_ARMED;      // arm
            end
            WD_ARMED: begin
                if (expire_hit)              state_n = WD_FIRE;  // expire
                else if (wr && !wdata[0])    state_n = WD_OFF;   // disarm
            end
            WD_FIRE: begin
                state_n = (wr && wdata[0]) ? WD_ARMED : WD_OFF;   // rearm / settle
            end
            default: state_n = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
        end else if (expire) begin
            upper_q <= '0;
        end else if (wr) begin
            upper_q <= wdata[CNT_W-1:1];
        end
    end

    always_comb begin
        reset_req = (state_q == WD_FIRE);
        wd_word   = {upper_q, (state_q == WD_ARMED)};
    end

endmodule

// File: rtl/ostimer_regbus.sv
module ostimer_regbus
    import ostimer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter int IEN_W  = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_rd,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [NUM_CH-1:0][CNT_W-1:0] targets,
    input  logic [CNT_W-1:0]             cnt,
    input  logic [NUM_CH-1:0]            status,
    input  logic [CNT_W-1:0]             wd_word,
    input  logic [IEN_W-1:0]             ien,
    output wr_strobe_t                   wstb,
    output logic [CNT_W-1:0]             rdata,
    output logic                         err
);

    rsp_state_e           state_q;
    rsp_state_e           state_n;
    logic                 mapped;
    logic [SLOT_BITS-1:0] slot;
    logic [CNT_W-1:0]     rd_mux;
    logic [CNT_W-1:0]     rdata_q;

    always_comb begin
        slot   = bus_addr[MAP_TOP-1:BYTE_BITS];
        mapped = (bus_addr[BYTE_BITS-1:0] == '0) &&
                 (bus_addr[ADDR_W-1:MAP_TOP] == '0);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_tgt_we
        assign wstb.match[g] = bus_wr && mapped && (slot == SLOT_BITS'(g));
    end

    always_comb begin
        wstb.count = bus_wr && mapped && (slot == SLOT_BITS'(SLOT_COUNT));
        wstb.stat  = bus_wr && mapped && (slot == SLOT_BITS'(SLOT_STAT));
        wstb.wdog  = bus_wr && mapped && (slot == SLOT_BITS'(SLOT_WDOG));
        wstb.ien   = bus_wr && mapped && (slot == SLOT_BITS'(SLOT_IEN));
    end

    always_comb begin
        rd_mux = '0;
        if (slot < SLOT_BITS'(NUM_CH)) begin
            rd_mux = targets[slot[1:0]];
        end else if (slot == SLOT_BITS'(SLOT_COUNT)) begin
            rd_mux = cnt;
        end else if (slot == SLOT_BITS'(SLOT_STAT)) begin
            rd_mux = {{(CNT_W-NUM_CH){1'b0}}, status};
        end else if (slot == SLOT_BITS'(SLOT_WDOG)) begin
            rd_mux = wd_word;
        end else begin
            rd_mux = {{(CNT_W-IEN_W){1'b0}}, ien};
        end
    end

    // response machine: one response state per cycle after a read strobe
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            RSP_IDLE, RSP_DATA, RSP_FAULT: begin
                if (!bus_rd)      state_n = RSP_IDLE;
                else if (mapped)  state_n = RSP_DATA;
                else              state_n = RSP_FAULT;
            end
            default: state_n = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= mapped ? rd_mux : '0;
        end
    end

    always_comb begin
        rdata = rdata_q;
        err   = (state_q == RSP_FAULT);
    end

endmodule

// File: rtl/ostimer_top.sv
module ostimer_top
    import ostimer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter int IEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              bus_err,
    output logic [NUM_CH-1:0] irq,
    output logic              reset_req
);

    localparam int WD_CH = NUM_CH - 1;

    wr_strobe_t                   wstb;
    logic [CNT_W-1:0]             cnt_q;
    logic [CNT_W-1:0]             cnt_next;
    logic                         cnt_upd;
    logic                         cnt_load;
    logic [NUM_CH-1:0][CNT_W-1:0] targets;
    logic [NUM_CH-1:0]            hit;
    logic [NUM_CH-1:0]            evt_set;
    logic [NUM_CH-1:0]            status;
    logic [IEN_W-1:0]             ien_q;
    logic [CNT_W-1:0]             wd_word;

    assign cnt_load = wstb.count;

    ostimer_regbus #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .IEN_W  (IEN_W)
    ) u_regbus (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .targets  (targets),
        .cnt      (cnt_q),
        .status   (status),
        .wd_word  (wd_word),
        .ien      (ien_q),
        .wstb     (wstb),
        .rdata    (bus_rdata),
        .err      (bus_err)
    );

    ostimer_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (cnt_load),
        .load_val (bus_wdata),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next),
        .cnt_upd  (cnt_upd)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        ostimer_match_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .target_we (wstb.match[ch]),
            .wdata     (bus_wdata),
            .cnt_next  (cnt_next),
            .cnt_upd   (cnt_upd),
            .enable    (ien_q[ch]),
            .clear     (wstb.stat && bus_wdata[ch]),
            .target_q  (targets[ch]),
            .hit       (hit[ch]),
            .set_evt   (evt_set[ch]),
            .status_q  (status[ch])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (wstb.ien) begin
            ien_q <= bus_wdata[IEN_W-1:0];
        end
    end

    ostimer_watchdog #(
        .CNT_W (CNT_W)
    ) u_watchdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wstb.wdog),
        .wdata      (bus_wdata),
        .expire_hit (hit[WD_CH]),
        .wd_word    (wd_word),
        .reset_req  (reset_req)
    );

    assign irq = status;

endmodule

// File: rtl/ostimer_sva.sv
module ostimer_sva #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter int IEN_W  = 12,
    parameter int NCH    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic              bus_err,
    input logic [NCH-1:0]    irq,
    input logic              reset_req,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              cnt_load,
    input logic [NCH-1:0]    evt_set,
    input logic [IEN_W-1:0]  ien_q
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(8'h14);
    localparam logic [CNT_W-1:0]  ONE       = {{(CNT_W-1){1'b0}}, 1'b1};

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_load) |=> (cnt_q == ($past(cnt_q) + ONE)));

    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cnt_load) |=> $stable(cnt_q));

    assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq) & ~$past(ien_q[NCH-1:0])) == '0));

    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == STAT_ADDR)) |=>
        ((irq & $past(bus_wdata[NCH-1:0]) & ~$past(evt_set)) == '0));

    assert_reset_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    assert_err_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd));

endmodule

bind ostimer_top ostimer_sva #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .IEN_W  (IEN_W),
    .NCH    (4)
) i_ostimer_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_err   (bus_err),
    .irq       (irq),
    .reset_req (reset_req),
    .cnt_q     (cnt_q),
    .cnt_load  (cnt_load),
    .evt_set   (evt_set),
    .ien_q     (ien_q)
);

// File: tb/test_ostimer_top.sv
`timescale 1ns/1ps
module test_ostimer_top;

    localparam logic [7:0] A_T0 = 8'h00, A_T1 = 8'h04, A_T2 = 8'h08, A_T3 = 8'h0C;
    localparam logic [7:0] A_CNT = 8'h10, A_ST = 8'h14, A_WD = 8'h18, A_IE = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  irq;
    logic        reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_cnt;
    logic [31:0] m_tgt [4];
    logic [31:0] m_wd;
    logic [11:0] m_ie;
    logic [3:0]  m_st;
    bit          m_rst;

    always #2.5 clk = ~clk;

    ostimer_top i_ostimer_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .irq       (irq),
        .reset_req (reset_req)
    );

    function automatic bit is_mapped(input logic [7:0] a);
        return (a[1:0] == 2'b00) && (a < 8'h20);
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (!is_mapped(a)) return 32'h0;
        case (a)
            A_T0, A_T1, A_T2, A_T3: return m_tgt[a[3:2]];
            A_CNT:                  return m_cnt;
            A_ST:                   return {28'h0, m_st};
            A_WD:                   return m_wd;
            default:                return {20'h0, m_ie};
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one bus/tick cycle: drive at negedge, update model at the edge, sample 1 ns later
    task automatic step(input bit t, input bit rd, input bit wr,
                        input logic [7:0] a, input logic [31:0] d, input string tag);
        logic [31:0] exp_rd;
        logic [31:0] nc;
        bit          upd;
        bit [3:0]    hit;
        bit          fire;
        @(negedge clk);
        tick_en = t; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        exp_rd = model_read(a);
        @(posedge clk);
        upd = 1'b1;
        if (wr && a == A_CNT) nc = d;
        else if (t)           nc = m_cnt + 32'd1;
        else begin nc = m_cnt; upd = 1'b0; end
        for (int k = 0; k < 4; k++) hit[k] = upd && (nc == m_tgt[k]);
        fire = hit[3] && m_wd[0];
        if (wr && a == A_ST) m_st = m_st & ~d[3:0];
        m_st = m_st | (hit & m_ie[3:0]);
        if (fire) m_wd = 32'h0;
        else if (wr && a == A_WD) m_wd = d;
        m_rst = fire;
        if (wr && a == A_IE) m_ie = d[11:0];
        if (wr && is_mapped(a) && a < A_CNT) m_tgt[a[3:2]] = d;
        m_cnt = nc;
        #1;
        if (rd) check(bus_rdata === exp_rd, tag, $sformatf("read @%h", a), bus_rdata, exp_rd);
        check(bus_err === (rd && !is_mapped(a)), "R9", "bus_err",
              {31'h0, bus_err}, {31'h0, rd && !is_mapped(a)});
        check(irq === m_st, "R4", "irq lines", {28'h0, irq}, {28'h0, m_st});
        check(reset_req === m_rst, m_rst ? "R7" : "R8", "reset_req",
              {31'h0, reset_req}, {31'h0, m_rst});
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        step(1'b0, 1'b0, 1'b1, a, d, "R9");
    endtask

    task automatic rd_reg(input logic [7:0] a, input string tag);
        step(1'b0, 1'b1, 1'b0, a, 32'h0, tag);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 8'h00, 32'h0, "R2");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] addrs [10];
        void'($urandom(32'd20240611));
        m_cnt = '0; m_wd = '0; m_ie = '0; m_st = '0; m_rst = 1'b0;
        for (int k = 0; k < 4; k++) m_tgt[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and output
        #1;
        check(irq === 4'h0, "R1", "irq after reset", {28'h0, irq}, 32'h0);
        check(reset_req === 1'b0, "R1", "reset_req after reset", {31'h0, reset_req}, 32'h0);
        for (int k = 0; k < 8; k++) rd_reg(8'(k * 4), "R1");

        // R2: wrap and load priority
        wr_reg(A_CNT, 32'hFFFF_FFFE);
        tick(3);
        rd_reg(A_CNT, "R2");
        step(1'b1, 1'b0, 1'b1, A_CNT, 32'h0000_0100, "R2");
        rd_reg(A_CNT, "R2");

        // R3: event only on update, not while stationary
        wr_reg(A_IE, 32'h1);
        wr_reg(A_T0, 32'd5);
        wr_reg(A_CNT, 32'd3);
        tick(2);
        rd_reg(A_ST, "R3");
        wr_reg(A_ST, 32'h1);
        rd_reg(A_ST, "R3");
        rd_reg(A_ST, "R3");

        // R5: set wins over clear in the same cycle, other bits untouched
        wr_reg(A_CNT, 32'd4);
        step(1'b1, 1'b0, 1'b1, A_ST, 32'hF, "R5");
        rd_reg(A_ST, "R5");
        wr_reg(A_ST, 32'h2);
        rd_reg(A_ST, "R5");

        // R4: disabled channel records nothing
        wr_reg(A_T1, 32'd50);
        wr_reg(A_CNT, 32'd49);
        tick(1);
        rd_reg(A_ST, "R4");

        // R6: enable mask
        wr_reg(A_IE, 32'hFFFF_FFFF);
        rd_reg(A_IE, "R6");
        wr_reg(A_IE, 32'h0);
        wr_reg(A_ST, 32'hF);

        // R7: watchdog expires without irq enable
        wr_reg(A_WD, 32'h0000_00F1);
        wr_reg(A_T3, 32'd100);
        wr_reg(A_CNT, 32'd98);
        tick(2);
        rd_reg(A_WD, "R7");

        // R8: disarmed watchdog keeps its word and requests nothing
        wr_reg(A_WD, 32'h0000_00F0);
        wr_reg(A_CNT, 32'd99);
        tick(1);
        rd_reg(A_WD, "R8");

        // R11: disarm, then rearm in the fire cycle
        wr_reg(A_WD, 32'h1);
        wr_reg(A_WD, 32'h4);
        rd_reg(A_WD, "R11");
        wr_reg(A_WD, 32'h1);
        wr_reg(A_CNT, 32'd99);
        tick(1);
        wr_reg(A_WD, 32'h3);
        rd_reg(A_WD, "R11");
        wr_reg(A_WD, 32'h0);

        // R9: unmapped reads and writes
        rd_reg(8'h20, "R9");
        rd_reg(8'h03, "R9");
        rd_reg(8'hFC, "R9");
        wr_reg(8'h24, 32'hDEAD_BEEF);
        wr_reg(8'h11, 32'h1234_5678);
        for (int k = 0; k < 8; k++) rd_reg(8'(k * 4), "R9");

        // R10: read and write to the same register in one cycle
        step(1'b0, 1'b1, 1'b1, A_T2, 32'hCAFE_0001, "R10");
        rd_reg(A_T2, "R10");

        // constrained random mix
        addrs = '{A_T0, A_T1, A_T2, A_T3, A_CNT, A_ST, A_WD, A_IE, 8'h2C, 8'h06};
        for (int k = 0; k < 4; k++) wr_reg(8'(k * 4), 32'd200 + 32'(k * 3));
        for (int n = 0; n < 4000; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int          op;
            bit          t;
            a  = addrs[$urandom % 10];
            op = int'($urandom % 3);
            t  = ($urandom % 2) == 0;
            case (a)
                A_CNT:                  d = m_tgt[$urandom % 4] - ($urandom % 4);
                A_T0, A_T1, A_T2, A_T3: d = 32'd195 + ($urandom % 20);
                A_WD:                   d = {$urandom} & 32'h0000_00FF;
                A_ST:                   d = {$urandom} & 32'hF;
                default:                d = $urandom;
            endcase
            step(t, op != 1, op != 0, a, d, "R10");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule